// File: doc/BRIEF.md
# Built-In Logic Block Observer Register

This block is an n-bit register that stands in for an ordinary system register so that the same flip-flops can serve in test. Two mode bits choose among four behaviours. The register can load its parallel inputs as a normal register, clear itself, shift serially as a scan chain, or compact its parallel inputs into a signature through linear feedback. When the parallel inputs are held at zero in signature mode, the register runs as a pseudo-random pattern generator.

The feedback taps come from a parameter. The default 8-bit polynomial is primitive, so the free-running generator visits all 255 non-zero states. A build-time option adds a concurrent variant. In that variant a separate generator register advances alongside the signature register, so the block can supply patterns and compact responses in the same cycles. A mode change takes effect at the next rising clock edge.

Top module: `bilbo_reg`

## Requirements
- R1: A synchronous active-high reset clears every stage at the next rising edge. In the concurrent variant it also loads the generator with its seed parameter.
- R2: With mode_hi=1 and mode_lo=1 (load mode), each stage takes its bit of par_in at the next rising edge.
- R3: With mode_hi=0 and mode_lo=1 (clear mode), every stage becomes 0 at the next rising edge.
- R4: With mode_hi=0 and mode_lo=0 (shift mode), stage 0 takes scan_in and stage i takes stage i-1. scan_out equals the highest stage in every mode.
- R5: With mode_hi=1 and mode_lo=0 (signature mode), stage 0 takes fb XOR par_in[0] and stage i takes stage i-1 XOR par_in[i]. Here fb is the XOR of the stages whose TAPS bit is 1, and TAPS bit i-1 stands for the x^i term.
- R6: In signature mode with par_in at zero and the default taps (x^8+x^4+x^3+x^2+1), a register seeded with 8'h01 first comes back to 8'h01 after exactly 255 cycles.
- R7: In signature mode with par_in at zero, an all-zero register stays at zero.
- R8: With WIDTH=3 and TAPS=3'b110, seed 3'b001 steps through 010, 101, 011, 111, 110, 100 and then 001.
- R9: With CONCURRENT=0, pattern_out equals par_out. With CONCURRENT=1, pattern_out is a separate generator with these rules:
  - it advances as in R6 on each signature-mode cycle;
  - it reloads SEED in clear mode;
  - it holds in the other modes;
  - par_out keeps behaving exactly as in R2 to R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_hi | input | 1 | Upper mode select bit |
| mode_lo | input | 1 | Lower mode select bit |
| par_in | input | WIDTH | Parallel data or response input |
| scan_in | input | 1 | Serial input to stage 0 |
| par_out | output | WIDTH | Register contents |
| scan_out | output | 1 | Highest stage, serial output |
| pattern_out | output | WIDTH | Generator output (equals par_out unless concurrent) |

## Verification
The assertions assume that the mode bits, par_in and scan_in are known and stable around each rising edge. They also assume that reset is asserted from time zero, so each one-cycle lookback starts from a defined state. The bench meets these assumptions by starting in reset and by changing every input only at the falling edge. It then steps a behavioural model of the register and the generator, and compares all outputs halfway through every cycle.

// File: rtl/bilbo_pkg.sv
package bilbo_pkg;

    typedef enum logic [1:0] {
        MODE_SHIFT = 2'b00,
        MODE_CLEAR = 2'b01,
        MODE_SIGN  = 2'b10,
        MODE_LOAD  = 2'b11
    } bilbo_mode_e;

    typedef struct packed {
        bilbo_mode_e mode;
        logic        gen_step;
        logic        gen_seed;
    } bilbo_ctrl_t;

endpackage

// File: rtl/bilbo_mode_dec.sv
module bilbo_mode_dec
    import bilbo_pkg::*;
(
    input  logic        mode_hi,
    input  logic        mode_lo,
    output bilbo_ctrl_t ctrl
);
    always_comb begin
        ctrl.mode     = bilbo_mode_e'({mode_hi, mode_lo});
        ctrl.gen_step = (ctrl.mode == MODE_SIGN);
        ctrl.gen_seed = (ctrl.mode == MODE_CLEAR);
    end
endmodule

// File: rtl/bilbo_next.sv
module bilbo_next
    import bilbo_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'h8E
) (
    input  bilbo_mode_e      mode,
    input  logic [WIDTH-1:0] cur,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] nxt
);
    logic             fb;
    logic [WIDTH-1:0] chain_vec;
    logic [WIDTH-1:0] sig_vec;

    assign fb        = ^(cur & TAPS);
    assign chain_vec = {cur[WIDTH-2:0], scan_in};
    assign sig_vec   = {cur[WIDTH-2:0], fb} ^ par_in;

    always_comb begin
        unique case (mode)
            MODE_LOAD:  nxt = par_in;
            MODE_CLEAR: nxt = '0;
            MODE_SHIFT: nxt = chain_vec;
            MODE_SIGN:  nxt = sig_vec;
            default:    nxt = cur;
        endcase
    end
endmodule

// File: rtl/bilbo_pattern_gen.sv
module bilbo_pattern_gen
    import bilbo_pkg::*;
#(
    parameter int               WIDTH = 8,
    parameter logic [WIDTH-1:0] TAPS  = 8'h8E,
    parameter logic [WIDTH-1:0] SEED  = 8'h01
) (
    input  logic             clk,
    input  logic             rst,
    input  bilbo_ctrl_t      ctrl,
    output logic [WIDTH-1:0] pat
);
    logic gen_fb;
    assign gen_fb = ^(pat & TAPS);

    always_ff @(posedge clk) begin
        if (rst || ctrl.gen_seed) begin
            pat <= SEED;
        end else if (ctrl.gen_step) begin
            pat <= {pat[WIDTH-2:0], gen_fb};
        end
    end
endmodule

// File: rtl/bilbo_reg.sv
module bilbo_reg
    import bilbo_pkg::*;
#(
    parameter int               WIDTH      = 8,
    parameter logic [WIDTH-1:0] TAPS       = 8'h8E,
    parameter bit               CONCURRENT = 1'b0,
    parameter logic [WIDTH-1:0] SEED       = {{(WIDTH-1){1'b0}}, 1'b1}
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_hi,
    input  logic             mode_lo,
    input  logic [WIDTH-1:0] par_in,
    input  logic             scan_in,
    output logic [WIDTH-1:0] par_out,
    output logic             scan_out,
    output logic [WIDTH-1:0] pattern_out
);
    localparam int LAST = WIDTH - 1;

    bilbo_ctrl_t      ctrl;
    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_d;

    bilbo_mode_dec u_dec (
        .mode_hi (mode_hi),
        .mode_lo (mode_lo),
        .ctrl    (ctrl)
    );

    bilbo_next #(.WIDTH(WIDTH), .TAPS(TAPS)) u_next (
        .mode    (ctrl.mode),
        .cur     (state_q),
        .par_in  (par_in),
        .scan_in (scan_in),
        .nxt     (state_d)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign par_out  = state_q;
    assign scan_out = state_q[LAST];

    generate
        if (CONCURRENT) begin : g_conc
            bilbo_pattern_gen #(.WIDTH(WIDTH), .TAPS(TAPS), .SEED(SEED)) u_gen (
                .clk  (clk),
                .rst  (rst),
                .ctrl (ctrl),
                .pat  (pattern_out)
            );
        end else begin : g_plain
            assign pattern_out = state_q;
        end
    endgenerate
endmodule

// File: rtl/bilbo_reg_chk.sv
module bilbo_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mode_hi,
    input logic             mode_lo,
    input logic [WIDTH-1:0] par_in,
    input logic             scan_in,
    input logic [WIDTH-1:0] par_out,
    input logic             scan_out
);
    assert_sync_clear_R1: assert property (@(posedge clk)
        rst |=> par_out == '0);

    assert_load_mode_R2: assert property (@(posedge clk) disable iff (rst)
        (mode_hi && mode_lo) |=> par_out == $past(par_in));

    assert_clear_mode_R3: assert property (@(posedge clk) disable iff (rst)
        (!mode_hi && mode_lo) |=> par_out == '0);

    assert_shift_mode_R4: assert property (@(posedge clk) disable iff (rst)
        (!mode_hi && !mode_lo) |=>
            (par_out[WIDTH-1:1] == $past(par_out[WIDTH-2:0])) && (par_out[0] == $past(scan_in)));

    assert_scan_tail_R4: assert property (@(posedge clk) disable iff (rst)
        scan_out == par_out[WIDTH-1]);

    assert_sign_chain_R5: assert property (@(posedge clk) disable iff (rst)
        (mode_hi && !mode_lo) |=>
            par_out[WIDTH-1:1] == ($past(par_out[WIDTH-2:0]) ^ $past(par_in[WIDTH-1:1])));

    assert_zero_lock_R7: assert property (@(posedge clk) disable iff (rst)
        (mode_hi && !mode_lo && par_out == '0 && par_in == '0) |=> par_out == '0);
endmodule

bind bilbo_reg bilbo_reg_chk #(.WIDTH(WIDTH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_hi  (mode_hi),
    .mode_lo  (mode_lo),
    .par_in   (par_in),
    .scan_in  (scan_in),
    .par_out  (par_out),
    .scan_out (scan_out)
);

// File: tb/bilbo_reg_test.sv
`timescale 1ns/1ps
module bilbo_reg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       mode_hi = 1'b1;
    logic       mode_lo = 1'b1;
    logic [7:0] z8 = '0;
    logic       sin = 1'b0;
    logic [2:0] z3 = '0;

    logic [7:0] q8, p8, qc, pc;
    logic       so8, soc;
    logic [2:0] q3, p3;
    logic       so3;

    int errors = 0;
    int checks = 0;

    logic [7:0] model;
    logic [7:0] pmodel;

    always #10 clk = ~clk;

    bilbo_reg uut (
        .clk(clk), .rst(rst), .mode_hi(mode_hi), .mode_lo(mode_lo),
        .par_in(z8), .scan_in(sin), .par_out(q8), .scan_out(so8), .pattern_out(p8)
    );

    bilbo_reg #(.CONCURRENT(1'b1), .SEED(8'h01)) uut_conc (
        .clk(clk), .rst(rst), .mode_hi(mode_hi), .mode_lo(mode_lo),
        .par_in(z8), .scan_in(sin), .par_out(qc), .scan_out(soc), .pattern_out(pc)
    );

    bilbo_reg #(.WIDTH(3), .TAPS(3'b110), .SEED(3'b001)) uut_small (
        .clk(clk), .rst(rst), .mode_hi(mode_hi), .mode_lo(mode_lo),
        .par_in(z3), .scan_in(sin), .par_out(q3), .scan_out(so3), .pattern_out(p3)
    );

    function automatic logic fb8(input logic [7:0] s);
        // x^2, x^3, x^4, x^8 terms -> stages 2, 3, 4 and 8 (indices 1, 2, 3, 7)
        return s[1] ^ s[2] ^ s[3] ^ s[7];
    endfunction

    function automatic logic [7:0] ref_reg(input logic [7:0] s, input logic [1:0] m,
                                           input logic [7:0] z, input logic si);
        logic [7:0] r;
        case (m)
            2'b11: r = z;
            2'b01: r = 8'h00;
            2'b00: begin
                r[0] = si;
                for (int i = 1; i < 8; i++) r[i] = s[i-1];
            end
            default: begin
                r[0] = fb8(s) ^ z[0];
                for (int i = 1; i < 8; i++) r[i] = s[i-1] ^ z[i];
            end
        endcase
        return r;
    endfunction

    function automatic logic [7:0] ref_gen(input logic [7:0] p, input logic [1:0] m);
        if (m == 2'b01) return 8'h01;
        if (m == 2'b10) return {p[6:0], fb8(p)};
        return p;
    endfunction

    task automatic check(input logic ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [1:0] m, input logic [7:0] z, input logic si, input string tag);
        mode_hi = m[1];
        mode_lo = m[0];
        z8      = z;
        sin     = si;
        @(posedge clk);
        model  = ref_reg(model, m, z, si);
        pmodel = ref_gen(pmodel, m);
        @(negedge clk);
        check(q8 === model, tag, q8, model);
        check(so8 === model[7], "R4 scan_out", {7'd0, so8}, {7'd0, model[7]});
        check(qc === model, "R9 concurrent par_out", qc, model);
        check(pc === pmodel, "R9 generator", pc, pmodel);
        check(p8 === q8, "R9 plain pattern_out", p8, q8);
    endtask

    initial begin : watchdog
        #(20ns * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        int lcg;
        logic [2:0] seq3 [7];
        int back;
        seq3 = '{3'b010, 3'b101, 3'b011, 3'b111, 3'b110, 3'b100, 3'b001};

        // R1: reset state
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        check(q8 === 8'h00, "R1 reset par_out", q8, 8'h00);
        check(so8 === 1'b0, "R1 reset scan_out", {7'd0, so8}, 8'h00);
        check(pc === 8'h01, "R1 generator seed", pc, 8'h01);
        model  = 8'h00;
        pmodel = 8'h01;
        rst    = 1'b0;

        // R2: load mode
        step(2'b11, 8'hA5, 1'b0, "R2 load");
        step(2'b11, 8'h3C, 1'b1, "R2 load");
        step(2'b11, 8'hFF, 1'b0, "R2 load");

        // R3: clear mode
        step(2'b01, 8'h77, 1'b1, "R3 clear");
        step(2'b11, 8'h81, 1'b0, "R2 load");

        // R4: shift mode
        for (int i = 0; i < 12; i++) step(2'b00, 8'h5A, 1'((i * 5 + 1) % 3 == 0), "R4 shift");

        // R5: signature mode with varied responses
        lcg = 17;
        for (int i = 0; i < 40; i++) begin
            lcg = (lcg * 73 + 41) % 256;
            step(2'b10, 8'(lcg), 1'b0, "R5 signature");
        end
        step(2'b00, 8'h00, 1'b1, "R4 shift");
        step(2'b11, 8'h00, 1'b0, "R2 load");
        step(2'b01, 8'h00, 1'b0, "R3 clear");

        // R6: maximal-length generator period
        step(2'b11, 8'h01, 1'b0, "R2 load seed");
        back = 0;
        for (int i = 1; i <= 255; i++) begin
            step(2'b10, 8'h00, 1'b0, "R6 generator");
            if (q8 === 8'h01 && back == 0) back = i;
        end
        check(back == 255, "R6 period", 8'(back), 8'hFF);

        // R7: all-zero lock
        step(2'b01, 8'h00, 1'b0, "R3 clear");
        for (int i = 0; i < 10; i++) step(2'b10, 8'h00, 1'b0, "R7 zero lock");
        check(q8 === 8'h00, "R7 stays zero", q8, 8'h00);

        // R8: three-stage sequence
        z3 = 3'b001;
        step(2'b11, 8'h01, 1'b0, "R2 load");
        check(q3 === 3'b001, "R8 seed", {5'd0, q3}, 8'h01);
        z3 = 3'b000;
        for (int i = 0; i < 7; i++) begin
            step(2'b10, 8'h00, 1'b0, "R6 generator");
            check(q3 === seq3[i], "R8 sequence", {5'd0, q3}, {5'd0, seq3[i]});
        end

        // R9: generator holds outside signature mode
        step(2'b11, 8'h44, 1'b0, "R9 hold load");
        step(2'b00, 8'h00, 1'b1, "R9 hold shift");
        step(2'b01, 8'h00, 1'b0, "R9 reseed");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule